// File: doc/BRIEF.md
# Host Serial Reader for a Sampling Converter

This block sits on the host side of a three-wire link to a slow, self-timed analog-to-digital converter. The converter exposes an active-low select, a serial clock input and a serial data output. After a start request, or continuously while auto-repeat is held, the reader first waits for the converter's worst-case conversion time. It then drops select with the serial clock parked low, which asks the converter to present its result. It toggles the clock sixteen times and captures one data bit on every rising edge.

When the last bit is captured, the reader presents the assembled word with a one-cycle strobe. It then finishes the sixteenth clock period and releases select, which lets the converter start its next conversion. An abort input raises select at once, and the converter treats that as the end of the read. Every timing value is counted in system clock cycles. The counts are derived at elaboration from the system clock rate and from nanosecond or microsecond limits.

Top module: `conv_reader`

## Requirements
- R1: After reset, select is high, the serial clock is high, busy is low, the strobe is low and the result word is zero.
- R2: Between a start request (or the end of the previous read in auto-repeat) and the fall of select, select stays high and busy stays high for at least the conversion wait of CONV_WAIT_US microseconds, converted to system clock cycles.
- R3: Select falls on the same clock edge that drives the serial clock low. The clock then stays low for at least the larger of the setup limit and the half-period limit before its first rise.
- R4: Each high phase and each low phase of the serial clock during a read lasts at least SCK_HALF_NS, rounded up to whole cycles. A complete read has exactly 16 rising edges.
- R5: The bit present on the data input at the first rising edge becomes bit 15 of the result. Later bits fill lower positions in order, so bit 0 comes from the 16th rising edge.
- R6: Each completed read raises the valid strobe for exactly one cycle. The strobe occurs while select is still low, and the full result word is on the data output in that cycle.
- R7: Select rises only after the 16th falling clock edge has been followed by a low phase. Whenever select is high, the serial clock is high.
- R8: An abort while busy raises select and the clock and clears busy on the next edge, with no strobe for the interrupted read. This holds during a transfer and during the wait.
- R9: A start request that arrives while busy is ignored and causes no additional read.
- R10: While auto-repeat is held, a new wait begins as soon as a read ends, and reads follow one another without further requests.
- R11: An abort while idle has no effect: select stays high and no read begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-shot read request, honoured only when idle |
| auto_i | input | 1 | Level: keep reading back to back |
| abort_i | input | 1 | Cancel the current wait or transfer |
| sdo_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low select to the converter |
| sck_o | output | 1 | Serial clock to the converter |
| busy_o | output | 1 | High while waiting or transferring |
| valid_o | output | 1 | One-cycle strobe with a new result |
| data_o | output | WORD_BITS | Last completed result, MSB first on the wire |

## Verification
Single reads are run with the words A5C3, 0000, FFFF and 8001. These separate bit-order mistakes, stuck capture paths and off-by-one shifts: a lost edge bit shows on 8001, and a reversed order shows on A5C3. A converter model on the bench reports each read's lead time, shortest clock phases, rising-edge count and pre-select wait. The timing limits are therefore checked per read rather than as a total. Abort is tried mid-transfer, mid-wait and while idle, and extra starts are issued during a wait and during a transfer. These cases separate an abort that truly releases the converter, and a start that is truly ignored, from one that silently begins another read. Auto-repeat runs three reads with a different word each time, to show that the wait is re-applied between reads.

// File: rtl/conv_reader_pkg.sv
package conv_reader_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_LEAD = 3'd2,
        ST_HIGH = 3'd3,
        ST_LOW  = 3'd4
    } rd_state_e;

    typedef struct packed {
        logic sel_n;
        logic clk;
    } pin_s;

    localparam pin_s PINS_PARKED = '{sel_n: 1'b1, clk: 1'b1};

    function automatic int ns_to_cyc(input int ns, input int mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    function automatic int us_to_cyc(input int us, input int mhz);
        return us * mhz;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int at_least_one(input int a);
        return (a < 1) ? 1 : a;
    endfunction

endpackage

// File: rtl/cr_timer.sv
module cr_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/cr_shift.sv
module cr_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[W-2:0], din};
        end
    end
endmodule

// File: rtl/cr_ctrl.sv
module cr_ctrl
    import conv_reader_pkg::*;
#(
    parameter int CONV_CYC = 100,
    parameter int LEAD_CYC = 13,
    parameter int HALF_CYC = 13,
    parameter int BITS     = 16,
    parameter int TW       = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          repeat_en,
    input  logic          abort,
    input  logic          tmr_zero,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          capture,
    output logic          last_bit,
    output logic          busy,
    output pin_s          pins
);
    localparam int BW = $clog2(BITS + 1);
    localparam logic [TW-1:0] CONV_LD = TW'(CONV_CYC - 1);
    localparam logic [TW-1:0] LEAD_LD = TW'(LEAD_CYC - 1);
    localparam logic [TW-1:0] HALF_LD = TW'(HALF_CYC - 1);

    rd_state_e     st, nxt;
    logic [BW-1:0] bit_cnt;
    pin_s          pins_d;

    always_comb begin
        nxt      = st;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start || repeat_en) begin
                    nxt      = ST_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CONV_LD;
                end
            end
            ST_WAIT: begin
                if (abort) begin
                    nxt = ST_IDLE;
                end else if (tmr_zero) begin
                    nxt      = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = LEAD_LD;
                end
            end
            ST_LEAD: begin
                if (abort) begin
                    nxt = ST_IDLE;
                end else if (tmr_zero) begin
                    nxt      = ST_HIGH;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_LD;
                    capture  = 1'b1;
                end
            end
            ST_HIGH: begin
                if (abort) begin
                    nxt = ST_IDLE;
                end else if (tmr_zero) begin
                    nxt      = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = HALF_LD;
                end
            end
            ST_LOW: begin
                if (abort) begin
                    nxt = ST_IDLE;
                end else if (tmr_zero) begin
                    if (bit_cnt == BW'(BITS)) begin
                        if (repeat_en) begin
                            nxt      = ST_WAIT;
                            tmr_load = 1'b1;
                            tmr_val  = CONV_LD;
                        end else begin
                            nxt = ST_IDLE;
                        end
                    end else begin
                        nxt      = ST_HIGH;
                        tmr_load = 1'b1;
                        tmr_val  = HALF_LD;
                        capture  = 1'b1;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        pins_d.sel_n = !(nxt == ST_LEAD || nxt == ST_HIGH || nxt == ST_LOW);
        pins_d.clk   = !(nxt == ST_LEAD || nxt == ST_LOW);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            pins    <= PINS_PARKED;
            bit_cnt <= '0;
        end else begin
            st   <= nxt;
            pins <= pins_d;
            if (st == ST_WAIT) begin
                bit_cnt <= '0;
            end else if (capture) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    assign last_bit = capture && (bit_cnt == BW'(BITS - 1));
    assign busy     = (st != ST_IDLE);
endmodule

// File: rtl/conv_reader.sv
module conv_reader
    import conv_reader_pkg::*;
#(
    parameter int CLK_MHZ      = 50,
    parameter int SCK_HALF_NS  = 250,
    parameter int CS_SETUP_NS  = 100,
    parameter int CONV_WAIT_US = 42000,
    parameter int WORD_BITS    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 auto_i,
    input  logic                 abort_i,
    input  logic                 sdo_i,
    output logic                 cs_n_o,
    output logic                 sck_o,
    output logic                 busy_o,
    output logic                 valid_o,
    output logic [WORD_BITS-1:0] data_o
);
    localparam int HALF_CYC = at_least_one(ns_to_cyc(SCK_HALF_NS, CLK_MHZ));
    localparam int SET_CYC  = at_least_one(ns_to_cyc(CS_SETUP_NS, CLK_MHZ));
    localparam int LEAD_CYC = max2(HALF_CYC, SET_CYC);
    localparam int CONV_CYC = at_least_one(us_to_cyc(CONV_WAIT_US, CLK_MHZ));
    localparam int TW       = $clog2(max2(CONV_CYC, LEAD_CYC) + 1);

    logic                 tmr_load, tmr_zero, capture, last_bit;
    logic [TW-1:0]        tmr_val;
    logic [WORD_BITS-1:0] sh_word;
    pin_s                 pins;

    cr_ctrl #(
        .CONV_CYC (CONV_CYC),
        .LEAD_CYC (LEAD_CYC),
        .HALF_CYC (HALF_CYC),
        .BITS     (WORD_BITS),
        .TW       (TW)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .repeat_en (auto_i),
        .abort     (abort_i),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .capture   (capture),
        .last_bit  (last_bit),
        .busy      (busy_o),
        .pins      (pins)
    );

    cr_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    cr_shift #(.W(WORD_BITS)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (capture),
        .din      (sdo_i),
        .word     (sh_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            data_o  <= '0;
        end else begin
            valid_o <= last_bit;
            if (last_bit) begin
                data_o <= {sh_word[WORD_BITS-2:0], sdo_i};
            end
        end
    end

    assign cs_n_o = pins.sel_n;
    assign sck_o  = pins.clk;
endmodule

// File: rtl/conv_reader_chk.sv
module conv_reader_chk (
    input logic clk,
    input logic rst,
    input logic abort_i,
    input logic cs_n_o,
    input logic sck_o,
    input logic busy_o,
    input logic valid_o
);
    // R3
    cs_fall_sck_low_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n_o) |-> !sck_o);

    // R7
    sck_parked_chk: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> sck_o);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R6
    valid_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> !cs_n_o);

    // R8
    abort_release_chk: assert property (@(posedge clk) disable iff (rst)
        (abort_i && busy_o) |=> (cs_n_o && sck_o && !busy_o && !valid_o));

    // R11
    idle_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> cs_n_o);
endmodule

bind conv_reader conv_reader_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .abort_i (abort_i),
    .cs_n_o  (cs_n_o),
    .sck_o   (sck_o),
    .busy_o  (busy_o),
    .valid_o (valid_o)
);

// File: tb/conv_reader_tb.sv
module conv_reader_tb;
    localparam int CLK_MHZ = 50;
    localparam int CONV_US = 2;
    localparam int HALF_E  = 13;   // 250 ns at 20 ns, rounded up
    localparam int LEAD_E  = 13;   // max(100 ns -> 5, 13)
    localparam int CONV_E  = 100;  // 2 us at 50 MHz

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0, auto_i = 1'b0, abort_i = 1'b0;
    logic        sdo_i = 1'b0;
    logic        cs_n_o, sck_o, busy_o, valid_o;
    logic [15:0] data_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [15:0] next_word = 16'h0;

    always #10 clk = ~clk;

    conv_reader #(
        .CLK_MHZ(CLK_MHZ), .SCK_HALF_NS(250), .CS_SETUP_NS(100),
        .CONV_WAIT_US(CONV_US), .WORD_BITS(16)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .auto_i(auto_i),
        .abort_i(abort_i), .sdo_i(sdo_i), .cs_n_o(cs_n_o), .sck_o(sck_o),
        .busy_o(busy_o), .valid_o(valid_o), .data_o(data_o)
    );

    // converter model and per-read measurements
    int n_rd = 0, n_val = 0, val_wide = 0;
    int gap_a[64], lead_a[64], mhi_a[64], mlo_a[64], rise_a[64], bad_a[64];
    logic [15:0] val_a[64];
    logic [15:0] mword = 16'h0;
    int bidx = 0, hi_run = 0, lo_run = 0, cs_hi_run = 0, cur = 0;
    logic p_cs = 1'b1, p_sck = 1'b1, p_val = 1'b0;

    always @(negedge clk) begin
        if (rst) begin
            p_cs = 1'b1; p_sck = 1'b1; p_val = 1'b0; cs_hi_run = 0;
        end else begin
            if (!cs_n_o) begin
                if (p_cs) begin
                    cur = n_rd & 63;
                    gap_a[cur] = cs_hi_run;
                    bad_a[cur] = sck_o ? 1 : 0;
                    mhi_a[cur] = 9999; mlo_a[cur] = 9999;
                    rise_a[cur] = 0; lead_a[cur] = 0;
                    mword = next_word + 16'(n_rd);
                    sdo_i = mword[15];
                    bidx = 14; lo_run = 1; hi_run = 0;
                    n_rd++;
                end else if (sck_o && !p_sck) begin
                    if (rise_a[cur] == 0) lead_a[cur] = lo_run;
                    else if (lo_run < mlo_a[cur]) mlo_a[cur] = lo_run;
                    rise_a[cur]++;
                    hi_run = 1;
                end else if (!sck_o && p_sck) begin
                    if (hi_run < mhi_a[cur]) mhi_a[cur] = hi_run;
                    lo_run = 1;
                    if (bidx >= 0) begin sdo_i = mword[bidx]; bidx--; end
                    else sdo_i = 1'b0;
                end else if (sck_o) hi_run++;
                else lo_run++;
                cs_hi_run = 0;
            end else begin
                if (!p_cs && rise_a[cur] == 16 && lo_run < mlo_a[cur])
                    mlo_a[cur] = lo_run;
                if (busy_o) cs_hi_run++; else cs_hi_run = 0;
            end
            if (valid_o) begin
                if (p_val) val_wide++;
                val_a[n_val & 63] = data_o;
                n_val++;
            end
            p_cs = cs_n_o; p_sck = sck_o; p_val = valid_o;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!busy_o) break;
        end
    endtask

    task automatic wait_rises(input int idx, input int n);
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (n_rd > idx && rise_a[idx & 63] >= n) break;
        end
    endtask

    task automatic check_read(input int idx, input int vidx, input logic [15:0] exp);
        int k = idx & 63;
        chk(gap_a[k] >= CONV_E, "R2", "wait before select", gap_a[k], CONV_E);
        chk(bad_a[k] == 0, "R3", "clock high at select fall", bad_a[k], 0);
        chk(lead_a[k] >= LEAD_E, "R3", "lead low time", lead_a[k], LEAD_E);
        chk(mhi_a[k] >= HALF_E, "R4", "shortest high phase", mhi_a[k], HALF_E);
        chk(mlo_a[k] >= HALF_E, "R4/R7", "shortest low phase incl. final", mlo_a[k], HALF_E);
        chk(rise_a[k] == 16, "R4", "rising edges", rise_a[k], 16);
        chk(val_a[vidx & 63] == exp, "R5", "result word", int'(val_a[vidx & 63]), int'(exp));
    endtask

    task automatic t_reset();
        chk(cs_n_o == 1'b1, "R1", "select after reset", cs_n_o, 1);
        chk(sck_o == 1'b1, "R1", "clock after reset", sck_o, 1);
        chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
        chk(valid_o == 1'b0, "R1", "strobe after reset", valid_o, 0);
        chk(data_o == 16'h0, "R1", "data after reset", int'(data_o), 0);
    endtask

    task automatic t_single(input logic [15:0] w);
        int rb = n_rd, vb = n_val;
        next_word = w - 16'(rb);
        pulse_start();
        chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        wait_idle();
        chk(n_rd - rb == 1, "R6", "reads per start", n_rd - rb, 1);
        chk(n_val - vb == 1, "R6", "strobes per read", n_val - vb, 1);
        chk(cs_n_o && sck_o, "R7", "pins parked at end", {cs_n_o, sck_o}, 3);
        check_read(rb, vb, w);
    endtask

    task automatic t_busy_start();
        int rb = n_rd, vb = n_val;
        next_word = 16'h3C5A - 16'(rb);
        pulse_start();
        repeat (30) @(negedge clk);
        chk(busy_o == 1'b1, "R9", "busy during wait", busy_o, 1);
        pulse_start();
        wait_rises(rb, 3);
        chk(busy_o == 1'b1, "R9", "busy during transfer", busy_o, 1);
        pulse_start();
        wait_idle();
        repeat (150) @(negedge clk);
        chk(n_rd - rb == 1, "R9", "reads after extra starts", n_rd - rb, 1);
        chk(n_val - vb == 1, "R9", "strobes after extra starts", n_val - vb, 1);
        chk(val_a[vb & 63] == 16'h3C5A, "R9", "word unaffected", int'(val_a[vb & 63]), 16'h3C5A);
    endtask

    task automatic t_abort_xfer();
        int rb = n_rd, vb = n_val;
        pulse_start();
        wait_rises(rb, 5);
        @(negedge clk) abort_i = 1'b1;
        @(negedge clk) abort_i = 1'b0;
        chk(cs_n_o == 1'b1, "R8", "select after abort", cs_n_o, 1);
        chk(sck_o == 1'b1, "R8", "clock after abort", sck_o, 1);
        chk(busy_o == 1'b0, "R8", "busy after abort", busy_o, 0);
        repeat (60) @(negedge clk);
        chk(n_val - vb == 0, "R8", "strobes after abort", n_val - vb, 0);
    endtask

    task automatic t_abort_wait();
        int rb = n_rd;
        pulse_start();
        repeat (20) @(negedge clk);
        abort_i = 1'b1;
        @(negedge clk) abort_i = 1'b0;
        chk(busy_o == 1'b0, "R8", "busy after wait abort", busy_o, 0);
        repeat (150) @(negedge clk);
        chk(n_rd - rb == 0, "R8", "reads after wait abort", n_rd - rb, 0);
    endtask

    task automatic t_abort_idle();
        int rb = n_rd;
        @(negedge clk) abort_i = 1'b1;
        @(negedge clk) abort_i = 1'b0;
        chk(cs_n_o == 1'b1 && busy_o == 1'b0, "R11", "idle abort pins/busy",
            {cs_n_o, busy_o}, 2);
        repeat (150) @(negedge clk);
        chk(n_rd - rb == 0, "R11", "reads after idle abort", n_rd - rb, 0);
        t_single(16'h1234);
    endtask

    task automatic t_auto();
        int rb = n_rd, vb = n_val;
        next_word = 16'h9000 - 16'(rb);
        @(negedge clk) auto_i = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (n_val - vb >= 3) break;
        end
        auto_i = 1'b0;
        wait_idle();
        chk(n_rd - rb == 3, "R10", "auto reads", n_rd - rb, 3);
        for (int j = 0; j < 3; j++)
            check_read(rb + j, vb + j, 16'h9000 + 16'(j));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single(16'hA5C3);
        t_single(16'h0000);
        t_single(16'hFFFF);
        t_single(16'h8001);
        t_busy_start();
        t_abort_xfer();
        t_abort_wait();
        t_abort_idle();
        t_auto();
        chk(val_wide == 0, "R6", "wide strobes", val_wide, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule